// File: doc/BRIEF.md
# Logarithmic-Format Multiply, Divide and Square Unit

This block is a single-stage arithmetic unit for signed numbers stored in a logarithmic format. Each operand carries a two-bit class tag, a sign bit, and the base-2 logarithm of its magnitude. That logarithm is a two's complement fixed-point value with `IW` integral bits and `FW` fractional bits, 11 and 52 by default. Because the magnitude is kept as a logarithm, multiplying two operands means adding their log fields. Dividing means subtracting the divisor's log field from the dividend's. Squaring means doubling the log field. No mantissa multiplier is needed.

The unit also handles signs and class tags. It catches results whose logarithm leaves the representable range, and it gives defined results for zero, infinity and not-a-number (NaN) operands. A two-bit opcode arrives with each operand pair and selects the operation. A valid bit marks each operand pair. Each result appears one clock later with its own valid bit. While no operand pair is offered, the output register keeps its last result.

Top module: `lgu_unit`

## Requirements
- R1: Class tags are coded 00 zero, 01 normal, 10 infinity and 11 NaN, on both the inputs and `out_tag`. Opcodes are coded 00 multiply, 01 divide, 10 square and 11 reserved. The reserved opcode always yields NaN.
- R2: Multiply of two normal operands gives `out_log = a_log + b_log` and `out_sign = a_sign XOR b_sign`, provided the sum is in range.
- R3: Divide of two normal operands gives `out_log = a_log - b_log` and `out_sign = a_sign XOR b_sign`, provided the difference is in range.
- R4: Square of a normal operand gives `out_log = 2 * a_log` with `out_sign = 0`. The b operand (tag, sign and log) has no effect on a square.
- R5: A log result above the largest representable value gives tag infinity. A log result below the most negative representable value gives tag zero. Results exactly at either limit stay normal.
- R6: The result is NaN when any operand that the operation uses is NaN, and also for zero times infinity (in either order), zero divided by zero, and infinity divided by infinity.
- R7: The remaining special cases are as follows. In multiply, zero with a normal or zero operand gives zero, and infinity with a normal or infinity operand gives infinity. In divide, a normal or infinity divided by zero gives infinity, zero divided by a normal or infinity gives zero, infinity divided by a normal gives infinity, and a normal divided by infinity gives zero. In square, zero gives zero and infinity gives infinity. For multiply and divide, the sign is the XOR of the operand signs in every case.
- R8: Whenever `out_tag` is not normal, `out_log` is all zeros.
- R9: A result is registered on the clock edge where `in_valid` is high, and `out_valid` is high for exactly that following cycle. When `in_valid` is low, `out_valid` goes low and `out_tag`, `out_sign` and `out_log` keep their values, whatever the other inputs do.
- R10: After reset, `out_valid`, `out_tag`, `out_sign` and `out_log` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair and opcode are present this cycle |
| in_op | input | 2 | Operation select |
| a_tag | input | 2 | Class tag of operand a |
| a_sign | input | 1 | Sign of operand a |
| a_log | input | IW+FW | Log2 magnitude of operand a, two's complement fixed point |
| b_tag | input | 2 | Class tag of operand b |
| b_sign | input | 1 | Sign of operand b |
| b_log | input | IW+FW | Log2 magnitude of operand b, two's complement fixed point |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| out_tag | output | 2 | Class tag of the result |
| out_sign | output | 1 | Sign of the result |
| out_log | output | IW+FW | Log2 magnitude of the result |

## Verification
Several properties are checked by the assertions on every cycle:
- the valid bit follows the input one cycle later;
- the registers hold while the input valid is low;
- the log field is cleared whenever the result is not normal;
- a square always has a positive sign;
- a NaN on operand a is always passed through as NaN;
- the internal overflow and underflow flags map to infinity and zero whenever the result is taken from the arithmetic.

Other behaviours can only be shown by the bench's scenarios. These are the exact sums, differences and doublings of the log fields, the full matrix of tag pairs under each opcode, and the values exactly at the range limits and one step past them.

// File: rtl/lgu_pkg.sv
package lgu_pkg;

  typedef enum logic [1:0] {
    TAG_ZERO = 2'b00,
    TAG_NORM = 2'b01,
    TAG_INF  = 2'b10,
    TAG_NAN  = 2'b11
  } lgu_tag_e;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_DIV = 2'b01,
    OP_SQR = 2'b10,
    OP_RSV = 2'b11
  } lgu_op_e;

  typedef struct packed {
    logic is_zero;
    logic is_norm;
    logic is_inf;
    logic is_nan;
  } lgu_cls_t;

  function automatic lgu_cls_t lgu_classify(input logic [1:0] tag);
    lgu_cls_t c;
    c.is_zero = (tag == TAG_ZERO);
    c.is_norm = (tag == TAG_NORM);
    c.is_inf  = (tag == TAG_INF);
    c.is_nan  = (tag == TAG_NAN);
    return c;
  endfunction

endpackage

// File: rtl/lgu_logcore.sv
module lgu_logcore #(
  parameter int IW = 11,
  parameter int FW = 52
) (
  input  logic [1:0]       op,
  input  logic [IW+FW-1:0] a_log,
  input  logic [IW+FW-1:0] b_log,
  output logic [IW+FW-1:0] res_log,
  output logic             ovf,
  output logic             unf
);
  import lgu_pkg::*;

  localparam int W  = IW + FW;
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] MINV = {3'b111, {(W-1){1'b0}}};

  // Log-domain arithmetic on a widened value so range escapes are visible.
  function automatic logic signed [XW-1:0] log_arith(
    input logic [1:0]   f_op,
    input logic [W-1:0] fa,
    input logic [W-1:0] fb
  );
    logic signed [XW-1:0] xa;
    logic signed [XW-1:0] xb;
    xa = {{2{fa[W-1]}}, fa};
    xb = {{2{fb[W-1]}}, fb};
    case (f_op)
      OP_MUL:  return xa + xb;
      OP_DIV:  return xa - xb;
      OP_SQR:  return xa <<< 1;
      default: return '0;
    endcase
  endfunction

  logic signed [XW-1:0] wide;

  always_comb begin
    wide    = log_arith(op, a_log, b_log);
    ovf     = (wide > MAXV);
    unf     = (wide < MINV);
    res_log = wide[W-1:0];
  end

endmodule

// File: rtl/lgu_tagcore.sv
module lgu_tagcore (
  input  logic [1:0] op,
  input  logic [1:0] a_tag,
  input  logic [1:0] b_tag,
  input  logic       a_sign,
  input  logic       b_sign,
  input  logic       ovf,
  input  logic       unf,
  output logic [1:0] res_tag,
  output logic       res_sign,
  output logic       norm_path
);
  import lgu_pkg::*;

  logic [1:0] tags [2];
  lgu_cls_t   cls  [2];

  assign tags[0] = a_tag;
  assign tags[1] = b_tag;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    assign cls[i] = lgu_classify(tags[i]);
  end

  function automatic logic [1:0] range_tag(input logic f_ovf, input logic f_unf);
    if (f_ovf)      return TAG_INF;
    else if (f_unf) return TAG_ZERO;
    else            return TAG_NORM;
  endfunction

  always_comb begin
    res_tag   = TAG_NAN;
    norm_path = 1'b0;
    res_sign  = a_sign ^ b_sign;
    case (op)
      OP_MUL: begin
        if (cls[0].is_nan || cls[1].is_nan)                                 res_tag = TAG_NAN;
        else if ((cls[0].is_zero && cls[1].is_inf) ||
                 (cls[0].is_inf && cls[1].is_zero))                         res_tag = TAG_NAN;
        else if (cls[0].is_zero || cls[1].is_zero)                          res_tag = TAG_ZERO;
        else if (cls[0].is_inf || cls[1].is_inf)                            res_tag = TAG_INF;
        else begin
          res_tag   = range_tag(ovf, unf);
          norm_path = 1'b1;
        end
      end
      OP_DIV: begin
        if (cls[0].is_nan || cls[1].is_nan)                                 res_tag = TAG_NAN;
        else if (cls[0].is_zero && cls[1].is_zero)                          res_tag = TAG_NAN;
        else if (cls[0].is_inf && cls[1].is_inf)                            res_tag = TAG_NAN;
        else if (cls[0].is_zero)                                            res_tag = TAG_ZERO;
        else if (cls[0].is_inf)                                             res_tag = TAG_INF;
        else if (cls[1].is_zero)                                            res_tag = TAG_INF;
        else if (cls[1].is_inf)                                             res_tag = TAG_ZERO;
        else begin
          res_tag   = range_tag(ovf, unf);
          norm_path = 1'b1;
        end
      end
      OP_SQR: begin
        res_sign = 1'b0;
        if (cls[0].is_nan)       res_tag = TAG_NAN;
        else if (cls[0].is_zero) res_tag = TAG_ZERO;
        else if (cls[0].is_inf)  res_tag = TAG_INF;
        else begin
          res_tag   = range_tag(ovf, unf);
          norm_path = 1'b1;
        end
      end
      default: begin
        res_sign = 1'b0;
        res_tag  = TAG_NAN;
      end
    endcase
  end

endmodule

// File: rtl/lgu_stage.sv
module lgu_stage #(
  parameter int W = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  input  logic [1:0]   d_tag,
  input  logic         d_sign,
  input  logic [W-1:0] d_log,
  output logic         q_valid,
  output logic [1:0]   q_tag,
  output logic         q_sign,
  output logic [W-1:0] q_log
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_tag   <= '0;
      q_sign  <= 1'b0;
      q_log   <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) begin
        q_tag  <= d_tag;
        q_sign <= d_sign;
        q_log  <= d_log;
      end
    end
  end

endmodule

// File: rtl/lgu_unit.sv
module lgu_unit #(
  parameter int IW = 11,
  parameter int FW = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [1:0]       a_tag,
  input  logic             a_sign,
  input  logic [IW+FW-1:0] a_log,
  input  logic [1:0]       b_tag,
  input  logic             b_sign,
  input  logic [IW+FW-1:0] b_log,
  output logic             out_valid,
  output logic [1:0]       out_tag,
  output logic             out_sign,
  output logic [IW+FW-1:0] out_log
);
  import lgu_pkg::*;

  localparam int W = IW + FW;

  // Named internal events, visible to the bound checker.
  logic [W-1:0] arith_log;
  logic         ovf_w;
  logic         unf_w;
  logic         norm_path_w;
  logic [1:0]   next_tag;
  logic         next_sign;
  logic [W-1:0] next_log;

  lgu_logcore #(.IW(IW), .FW(FW)) u_logcore (
    .op      (in_op),
    .a_log   (a_log),
    .b_log   (b_log),
    .res_log (arith_log),
    .ovf     (ovf_w),
    .unf     (unf_w)
  );

  lgu_tagcore u_tagcore (
    .op        (in_op),
    .a_tag     (a_tag),
    .b_tag     (b_tag),
    .a_sign    (a_sign),
    .b_sign    (b_sign),
    .ovf       (ovf_w),
    .unf       (unf_w),
    .res_tag   (next_tag),
    .res_sign  (next_sign),
    .norm_path (norm_path_w)
  );

  assign next_log = (next_tag == TAG_NORM) ? arith_log : '0;

  lgu_stage #(.W(W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_tag   (next_tag),
    .d_sign  (next_sign),
    .d_log   (next_log),
    .q_valid (out_valid),
    .q_tag   (out_tag),
    .q_sign  (out_sign),
    .q_log   (out_log)
  );

endmodule

// File: rtl/lgu_unit_chk.sv
module lgu_unit_chk #(
  parameter int W = 63
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [1:0]   in_op,
  input logic [1:0]   a_tag,
  input logic         norm_path_w,
  input logic         ovf_w,
  input logic         unf_w,
  input logic         out_valid,
  input logic [1:0]   out_tag,
  input logic         out_sign,
  input logic [W-1:0] out_log
);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R9
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_tag) && $stable(out_sign) && $stable(out_log)));  // R9
  AST_SPECIAL_LOG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag != 2'b01) |-> (out_log == '0));  // R8
  AST_SQUARE_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10) |=> !out_sign);  // R4
  AST_NAN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && a_tag == 2'b11) |=> (out_tag == 2'b11));  // R6
  AST_RESERVED_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b11) |=> (out_tag == 2'b11));  // R1
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && norm_path_w && ovf_w) |=> (out_tag == 2'b10));  // R5
  AST_UNDERFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && norm_path_w && unf_w) |=> (out_tag == 2'b00));  // R5
  AST_INRANGE_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && norm_path_w && !ovf_w && !unf_w) |=> (out_tag == 2'b01));  // R5

endmodule

bind lgu_unit lgu_unit_chk #(.W(IW+FW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_op       (in_op),
  .a_tag       (a_tag),
  .norm_path_w (norm_path_w),
  .ovf_w       (ovf_w),
  .unf_w       (unf_w),
  .out_valid   (out_valid),
  .out_tag     (out_tag),
  .out_sign    (out_sign),
  .out_log     (out_log)
);

// File: tb/lgu_unit_bench.sv
module lgu_unit_bench;

  localparam int IW = 11;
  localparam int FW = 52;
  localparam int W  = IW + FW;
  localparam longint MAXL = (64'sd1 <<< (W-1)) - 1;
  localparam longint MINL = -(64'sd1 <<< (W-1));

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   in_op = '0;
  logic [1:0]   a_tag = '0;
  logic         a_sign = 1'b0;
  logic [W-1:0] a_log = '0;
  logic [1:0]   b_tag = '0;
  logic         b_sign = 1'b0;
  logic [W-1:0] b_log = '0;
  logic         out_valid;
  logic [1:0]   out_tag;
  logic         out_sign;
  logic [W-1:0] out_log;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [W+2:0] q_exp [$];
  string        q_req [$];

  always #5 clk = ~clk;

  lgu_unit #(.IW(IW), .FW(FW)) u_lgu_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .a_tag(a_tag), .a_sign(a_sign), .a_log(a_log),
    .b_tag(b_tag), .b_sign(b_sign), .b_log(b_log),
    .out_valid(out_valid), .out_tag(out_tag), .out_sign(out_sign), .out_log(out_log)
  );

  task automatic check(input string req, input logic [W+2:0] act, input logic [W+2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model, organised by result class first.
  function automatic logic [W+2:0] model(input logic [1:0] op,
      input logic [1:0] at, input logic as, input logic [W-1:0] al,
      input logic [1:0] bt, input logic bs, input logic [W-1:0] bl);
    longint la, lb, r;
    logic [1:0] t;
    logic s;
    bit use_b;
    la = longint'($signed(al));
    lb = longint'($signed(bl));
    use_b = (op != 2'b10);
    s = (op == 2'b10 || op == 2'b11) ? 1'b0 : (as ^ bs);
    r = 0;
    if (op == 2'b11 || at == 2'b11 || (use_b && bt == 2'b11)) t = 2'b11;
    else if (op == 2'b00 && ((at == 2'b00 && bt == 2'b10) || (at == 2'b10 && bt == 2'b00))) t = 2'b11;
    else if (op == 2'b01 && at == bt && at != 2'b01) t = 2'b11;
    else if (op == 2'b10) begin
      if (at == 2'b01) begin r = la * 2; t = 2'b01; end
      else t = at;
    end else if (at == 2'b01 && bt == 2'b01) begin
      r = (op == 2'b00) ? la + lb : la - lb;
      t = 2'b01;
    end else if (op == 2'b00) t = (at == 2'b00 || bt == 2'b00) ? 2'b00 : 2'b10;
    else t = (at == 2'b00 || bt == 2'b10) ? 2'b00 : 2'b10;
    if (t == 2'b01 && r > MAXL) t = 2'b10;
    if (t == 2'b01 && r < MINL) t = 2'b00;
    if (t != 2'b01) r = 0;
    return {t, s, r[W-1:0]};
  endfunction

  task automatic drive(input string req, input logic [1:0] op,
      input logic [1:0] at, input logic as, input longint al,
      input logic [1:0] bt, input logic bs, input longint bl);
    @(negedge clk);
    in_valid = 1'b1; in_op = op;
    a_tag = at; a_sign = as; a_log = al[W-1:0];
    b_tag = bt; b_sign = bs; b_log = bl[W-1:0];
    q_exp.push_back(model(op, at, as, al[W-1:0], bt, bs, bl[W-1:0]));
    q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_op = 2'(i); a_tag = 2'b11; b_tag = 2'b10; a_sign = 1'b1;
      a_log = {W{1'b1}}; b_log = '0;
    end
  endtask

  // Monitor: compare each valid result against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      if (q_exp.size() == 0) check("R9", 1'b1, 1'b0);
      else check(q_req.pop_front(), {out_tag, out_sign, out_log}, q_exp.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W+2:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R10", {out_valid, out_tag, out_sign, out_log}, '0);
    @(negedge clk); rst_n = 1'b1;

    // R2 multiply of normals
    drive("R2", 2'b00, 2'b01, 1'b0, 64'sd1000, 2'b01, 1'b0, 64'sd2345);
    drive("R2", 2'b00, 2'b01, 1'b1, -64'sd77777, 2'b01, 1'b0, 64'sd5);
    drive("R2", 2'b00, 2'b01, 1'b1, 64'sd1 <<< 55, 2'b01, 1'b1, -(64'sd3 <<< 50));
    // R3 divide of normals
    drive("R3", 2'b01, 2'b01, 1'b0, 64'sd500, 2'b01, 1'b1, 64'sd900);
    drive("R3", 2'b01, 2'b01, 1'b1, -64'sd123456789, 2'b01, 1'b1, -64'sd987);
    // R4 square, b operand varied including NaN
    drive("R4", 2'b10, 2'b01, 1'b1, 64'sd4242, 2'b11, 1'b1, 64'sd99);
    drive("R4", 2'b10, 2'b01, 1'b0, -64'sd31337, 2'b00, 1'b0, 64'sd0);
    drive("R4", 2'b10, 2'b01, 1'b1, 64'sd4242, 2'b10, 1'b0, -64'sd1);
    // R5 range limits
    drive("R5", 2'b00, 2'b01, 1'b0, MAXL, 2'b01, 1'b0, 64'sd0);
    drive("R5", 2'b00, 2'b01, 1'b0, MAXL, 2'b01, 1'b0, 64'sd1);
    drive("R5", 2'b00, 2'b01, 1'b0, MINL, 2'b01, 1'b0, 64'sd0);
    drive("R5", 2'b00, 2'b01, 1'b0, MINL, 2'b01, 1'b0, -64'sd1);
    drive("R5", 2'b01, 2'b01, 1'b0, MAXL, 2'b01, 1'b0, -64'sd1);
    drive("R5", 2'b01, 2'b01, 1'b1, MINL, 2'b01, 1'b0, 64'sd1);
    drive("R5", 2'b10, 2'b01, 1'b0, (MAXL >>> 1) + 1, 2'b01, 1'b0, 64'sd0);
    drive("R5", 2'b10, 2'b01, 1'b0, MINL >>> 1, 2'b01, 1'b0, 64'sd0);
    drive("R5", 2'b10, 2'b01, 1'b0, (MINL >>> 1) - 1, 2'b01, 1'b0, 64'sd0);
    idle(2);
    // R6 R7 full tag matrix per opcode (R1 coding), with gaps
    for (int op = 0; op < 4; op++) begin
      for (int ta = 0; ta < 4; ta++) begin
        for (int tb = 0; tb < 4; tb++) begin
          drive((op == 3) ? "R1" : ((ta == 3 || tb == 3 || ta == tb) ? "R6" : "R7"),
                2'(op), 2'(ta), 1'(ta), 64'sd777, 2'(tb), 1'(tb >> 1), 64'sd333);
        end
        if (ta == 1) idle(1);
      end
    end
    // R8 special results clear the log field: zero operand with big log
    drive("R8", 2'b00, 2'b00, 1'b0, MAXL, 2'b01, 1'b0, MAXL);
    drive("R8", 2'b01, 2'b01, 1'b1, 64'sd5555, 2'b00, 1'b0, 64'sd1);
    // R9 hold while idle
    drive("R9", 2'b00, 2'b01, 1'b1, 64'sd12, 2'b01, 1'b0, 64'sd30);
    held = model(2'b00, 2'b01, 1'b1, 63'd12, 2'b01, 1'b0, 63'd30);
    idle(4);
    #1;
    check("R9", {out_valid, out_tag, out_sign, out_log}, {1'b0, held});
    idle(2);
    check("R9", q_exp.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule